// File: doc/BRIEF.md
# Multi-Channel Direct Digital Synthesizer with Frequency, Phase and Keyed Modulation

This block generates sampled waveforms for several output channels from a single shared waveform table. Each channel keeps its own 32-bit phase accumulator. One channel is served per clock, in round-robin order. When a channel is served, its accumulator advances by a step. The step is the channel's base frequency word plus a scaled frequency-modulation input. In the keyed modes it is instead one of two frequency words, chosen by a stored bit pattern or by an external bit. The phase offset and a phase-modulation input are added to the accumulator. The top bits of that sum address the channel's region of the table, and the sample read there becomes the channel's DAC word.

The table is one single-port RAM split into equal regions, one per channel. At run time each channel may point at any region, so several channels can share one waveform bank. A table write takes the RAM for one clock and pauses the rotation for that clock. A channel can also be set to output the average of two other channels' current samples, which gives a linear mix. Configuration uses a simple write port that carries a channel number, a register select and a data word.

Top module: `mcdds_top`

## Requirements
- R1: While reset is held (active low, synchronous), every DAC word is zero. After reset the rotation starts at channel 0, all accumulators and pattern positions are zero, and every channel's region select equals its own channel number.
- R2: On each clock without a table write, exactly one channel is served, in the order 0, 1, …, NCH-1, 0, … Its accumulator advances by its step. The sample looked up for it is written to its DAC word at the following clock edge.
- R3: The table address for a served channel is region × 2^RAW plus the top RAW bits of (accumulator + phase register + PM input × 2^(32−PM_W)), taken modulo 2^32. The accumulator value used is the one from before it advances. PM_IN is a signed 8-bit field per channel.
- R4: In plain mode (mode code 0) the step is the frequency-0 word plus FM input × sensitivity. FM_IN is a signed 8-bit field per channel, and the sensitivity is unsigned 8-bit.
- R5: The step is limited to the range 0 to 2^31, which is half a table cycle per sample. A negative sum gives 0, and a sum above 2^31 gives 2^31.
- R6: In stored-keying mode (mode code 1), each served sample uses bit k of the 16-bit pattern register. A 1 selects the frequency-1 word and a 0 selects the frequency-0 word. k starts at 0 (the LSB), advances by one after each served sample, and wraps after bit 15. Writing the pattern register sets k back to 0.
- R7: In external-keying mode (mode code 2), the FSK_EXT input sampled in the serving cycle selects the frequency-1 word (1) or the frequency-0 word (0). The FM term is added in both keying modes.
- R8: Writing a frequency word never resets or changes the accumulator. The new word applies from the channel's next served sample, so the phase stays continuous.
- R9: In mix mode (mode code 3), the channel's DAC word is updated, one edge after the channel is served, with floor((A + B) / 2). A and B are the DAC words of the two source channels just before that edge.
- R10: In a clock with TBL_WE high, TBL_DATA is written at TBL_ADDR. No channel is served in that clock: the rotation holds, and every accumulator and pattern position keeps its value.
- R11: A register write (CFG_WE high) updates the selected register of channel CFG_CH at the clock edge. Select codes: 0 frequency-0 word, 1 frequency-1 word, 2 phase offset, 3 sensitivity (data[7:0]), 4 mode (data[1:0]), 5 region select (data[1:0]), 6 mix sources (source A in data[1:0], source B in data[3:2]), 7 keying pattern (data[15:0]).
- R12: A channel's region select picks which equal table region its lookups read. Changing it moves the channel to another waveform bank without affecting its accumulator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_ch | input | 2 | Channel addressed by the write |
| cfg_sel | input | 3 | Register select code |
| cfg_data | input | 32 | Register write data |
| tbl_we | input | 1 | Waveform table write strobe (pauses rotation) |
| tbl_addr | input | 8 | Table write address (region in top bits) |
| tbl_data | input | 8 | Table write data |
| fm_in | input | 32 | Signed 8-bit FM input per channel, channel i at [8i+7:8i] |
| pm_in | input | 32 | Signed 8-bit PM input per channel, channel i at [8i+7:8i] |
| fsk_ext | input | 1 | External keying bit |
| dac_out | output | 32 | 8-bit sample word per channel, channel i at [8i+7:8i] |

## Verification
The assertions assume that a table write and the rotation never share the RAM. They also assume that a pattern rewrite is the only event that restarts a channel's pattern position, and that every served step fits within half a table cycle. The properties check that these rules hold over time. The stimulus loads every table entry while TBL_WE is held high from before reset release, so no lookup ever reads an unwritten word. Inputs change only on falling edges, so register writes, keying bits and modulation values are stable at the edge that uses them. Table rewrites during the run are single-cycle pulses spread among served cycles, so the pause is exercised without stopping the rotation for long.

// File: rtl/mcdds_pkg.sv
// Shared encodings for the multi-channel synthesizer.
// Assumes: register select is three bits wide, mode field two bits wide.
package mcdds_pkg;

    typedef enum logic [1:0] {
        MODE_PLAIN   = 2'd0,
        MODE_FSK_MEM = 2'd1,
        MODE_FSK_EXT = 2'd2,
        MODE_BLEND   = 2'd3
    } wave_mode_e;

    localparam logic [2:0] SEL_F0   = 3'd0;
    localparam logic [2:0] SEL_F1   = 3'd1;
    localparam logic [2:0] SEL_PH   = 3'd2;
    localparam logic [2:0] SEL_KF   = 3'd3;
    localparam logic [2:0] SEL_MODE = 3'd4;
    localparam logic [2:0] SEL_BANK = 3'd5;
    localparam logic [2:0] SEL_MIX  = 3'd6;
    localparam logic [2:0] SEL_BITS = 3'd7;

endpackage

// File: rtl/mcdds_regs.sv
// Per-channel configuration registers, written through one narrow port.
// Assumes: one write per clock; region select resets to the channel index.
module mcdds_regs
    import mcdds_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int CH_W   = 2,
    parameter int PW     = 32,
    parameter int KF_W   = 8,
    parameter int BITS_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [CH_W-1:0]    cfg_ch,
    input  logic [2:0]         cfg_sel,
    input  logic [PW-1:0]      cfg_data,
    output logic [PW-1:0]      f0_o   [NCH],
    output logic [PW-1:0]      f1_o   [NCH],
    output logic [PW-1:0]      ph_o   [NCH],
    output logic [KF_W-1:0]    kf_o   [NCH],
    output wave_mode_e         mode_o [NCH],
    output logic [CH_W-1:0]    bank_o [NCH],
    output logic [CH_W-1:0]    sa_o   [NCH],
    output logic [CH_W-1:0]    sb_o   [NCH],
    output logic [BITS_W-1:0]  pat_o  [NCH],
    output logic [NCH-1:0]     pat_wr_o
);

    // Register file update: reset defaults, then addressed field writes.
    always_ff @(posedge clk) begin
        for (int i = 0; i < NCH; i++) begin
            if (!rst_n) begin
                f0_o[i]   <= '0;
                f1_o[i]   <= '0;
                ph_o[i]   <= '0;
                kf_o[i]   <= '0;
                mode_o[i] <= MODE_PLAIN;
                bank_o[i] <= CH_W'(i);
                sa_o[i]   <= '0;
                sb_o[i]   <= '0;
                pat_o[i]  <= '0;
            end else if (cfg_we && cfg_ch == CH_W'(i)) begin
                case (cfg_sel)
                    SEL_F0:   f0_o[i]   <= cfg_data;
                    SEL_F1:   f1_o[i]   <= cfg_data;
                    SEL_PH:   ph_o[i]   <= cfg_data;
                    SEL_KF:   kf_o[i]   <= cfg_data[KF_W-1:0];
                    SEL_MODE: mode_o[i] <= wave_mode_e'(cfg_data[1:0]);
                    SEL_BANK: bank_o[i] <= cfg_data[CH_W-1:0];
                    SEL_MIX: begin
                        sa_o[i] <= cfg_data[CH_W-1:0];
                        sb_o[i] <= cfg_data[2*CH_W-1:CH_W];
                    end
                    default:  pat_o[i]  <= cfg_data[BITS_W-1:0];
                endcase
            end
        end
    end

    // Pattern-rewrite strobe per channel, used to restart the bit position.
    always_comb begin
        for (int i = 0; i < NCH; i++)
            pat_wr_o[i] = cfg_we && (cfg_sel == SEL_BITS) && (cfg_ch == CH_W'(i));
    end

    for (genvar i = 0; i < NCH; i++) begin : g_chk
        // R11: a frequency-0 write lands in the addressed channel
        a_r11_f0_write: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_we && cfg_sel == SEL_F0 && cfg_ch == CH_W'(i)) |=> (f0_o[i] == $past(cfg_data)));
    end

endmodule

// File: rtl/mcdds_step.sv
// Phase-step calculator: picks the frequency word for the mode, adds the
// scaled FM term and limits the result to 0..2^(PW-1).
// Assumes: FM input is signed, sensitivity unsigned.
module mcdds_step
    import mcdds_pkg::*;
#(
    parameter int PW   = 32,
    parameter int FM_W = 8,
    parameter int KF_W = 8
) (
    input  logic [PW-1:0]    f0_i,
    input  logic [PW-1:0]    f1_i,
    input  wave_mode_e       mode_i,
    input  logic             pat_bit_i,
    input  logic             ext_bit_i,
    input  logic [FM_W-1:0]  fm_i,
    input  logic [KF_W-1:0]  kf_i,
    output logic [PW-1:0]    step_o
);

    localparam int FMK = FM_W + KF_W + 1;
    localparam logic signed [PW+1:0] CAP = (PW+2)'(1) << (PW-1);

    logic                    use_one;
    logic [PW-1:0]           f_sel;
    logic signed [FMK-1:0]   fm_term;
    logic signed [PW+1:0]    raw;

    // Step selection, modulation sum and half-rate limit.
    always_comb begin
        case (mode_i)
            MODE_FSK_MEM: use_one = pat_bit_i;
            MODE_FSK_EXT: use_one = ext_bit_i;
            default:      use_one = 1'b0;
        endcase
        f_sel   = use_one ? f1_i : f0_i;
        fm_term = $signed(fm_i) * $signed({1'b0, kf_i});
        raw     = $signed({2'b00, f_sel}) + $signed({{(PW+2-FMK){fm_term[FMK-1]}}, fm_term});
        if (raw[PW+1])
            step_o = '0;
        else if (raw > CAP)
            step_o = PW'(CAP);
        else
            step_o = PW'(raw);
    end

endmodule

// File: rtl/mcdds_wave_ram.sv
// Single-port waveform table with registered read.
// Assumes: a write cycle produces no read; the caller ignores q then.
module mcdds_wave_ram #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] q
);

    logic [DW-1:0] mem [1<<AW];

    // One access per clock: write, or registered read.
    always_ff @(posedge clk) begin
        if (we)
            mem[addr] <= wdata;
        else
            q <= mem[addr];
    end

endmodule

// File: rtl/mcdds_top.sv
// Multi-channel direct digital synthesizer. Channels are served round-robin,
// one per clock, from one shared table split into NCH regions of 2^RAW words.
// Assumes: NCH is a power of two >= 2, BITS_W is a power of two.
module mcdds_top
    import mcdds_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int PW     = 32,
    parameter int RAW    = 6,
    parameter int DW     = 8,
    parameter int FM_W   = 8,
    parameter int PM_W   = 8,
    parameter int KF_W   = 8,
    parameter int BITS_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [$clog2(NCH)-1:0] cfg_ch,
    input  logic [2:0]           cfg_sel,
    input  logic [PW-1:0]        cfg_data,
    input  logic                 tbl_we,
    input  logic [$clog2(NCH)+RAW-1:0] tbl_addr,
    input  logic [DW-1:0]        tbl_data,
    input  logic [NCH*FM_W-1:0]  fm_in,
    input  logic [NCH*PM_W-1:0]  pm_in,
    input  logic                 fsk_ext,
    output logic [NCH*DW-1:0]    dac_out
);

    localparam int CH_W  = $clog2(NCH);
    localparam int AW    = CH_W + RAW;
    localparam int IDX_W = $clog2(BITS_W);
    localparam logic [PW-1:0] STEP_CAP = PW'(1) << (PW-1);

    logic [PW-1:0]     f0_a [NCH];
    logic [PW-1:0]     f1_a [NCH];
    logic [PW-1:0]     ph_a [NCH];
    logic [KF_W-1:0]   kf_a [NCH];
    wave_mode_e        mode_a [NCH];
    logic [CH_W-1:0]   bank_a [NCH];
    logic [CH_W-1:0]   sa_a [NCH];
    logic [CH_W-1:0]   sb_a [NCH];
    logic [BITS_W-1:0] pat_a [NCH];
    logic [NCH-1:0]    pat_wr;

    logic [FM_W-1:0]   fm_a [NCH];
    logic [PM_W-1:0]   pm_a [NCH];
    logic [PW-1:0]     acc [NCH];
    logic [IDX_W-1:0]  bit_idx [NCH];
    logic [DW-1:0]     out_q [NCH];
    logic [NCH*PW-1:0] acc_flat;

    logic [CH_W-1:0]   slot;
    logic              serve;
    logic [PW-1:0]     step;
    logic [RAW-1:0]    look_hi;
    logic [AW-1:0]     ram_addr;
    logic [DW-1:0]     ram_q;
    logic              rd_vld;
    logic [CH_W-1:0]   rd_ch;
    logic              rd_blend;
    logic [CH_W-1:0]   rd_sa;
    logic [CH_W-1:0]   rd_sb;

    mcdds_regs #(
        .NCH(NCH), .CH_W(CH_W), .PW(PW), .KF_W(KF_W), .BITS_W(BITS_W)
    ) regs_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ch(cfg_ch),
        .cfg_sel(cfg_sel), .cfg_data(cfg_data),
        .f0_o(f0_a), .f1_o(f1_a), .ph_o(ph_a), .kf_o(kf_a), .mode_o(mode_a),
        .bank_o(bank_a), .sa_o(sa_a), .sb_o(sb_a), .pat_o(pat_a),
        .pat_wr_o(pat_wr)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_lane
        assign fm_a[i] = fm_in[i*FM_W +: FM_W];
        assign pm_a[i] = pm_in[i*PM_W +: PM_W];
        assign dac_out[i*DW +: DW] = out_q[i];
        assign acc_flat[i*PW +: PW] = acc[i];
    end

    assign serve = !tbl_we;

    mcdds_step #(
        .PW(PW), .FM_W(FM_W), .KF_W(KF_W)
    ) step_i (
        .f0_i(f0_a[slot]), .f1_i(f1_a[slot]), .mode_i(mode_a[slot]),
        .pat_bit_i(pat_a[slot][bit_idx[slot]]), .ext_bit_i(fsk_ext),
        .fm_i(fm_a[slot]), .kf_i(kf_a[slot]), .step_o(step)
    );

    // Table address of the served channel: phase sum top bits plus region base.
    always_comb begin
        look_hi  = RAW'((acc[slot] + ph_a[slot] + {pm_a[slot], {(PW-PM_W){1'b0}}}) >> (PW-RAW));
        ram_addr = tbl_we ? tbl_addr : {bank_a[slot], look_hi};
    end

    mcdds_wave_ram #(
        .AW(AW), .DW(DW)
    ) ram_i (
        .clk(clk), .we(tbl_we), .addr(ram_addr), .wdata(tbl_data), .q(ram_q)
    );

    // Rotation pointer and lookup pipeline tag; both hold on a table write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot     <= '0;
            rd_vld   <= 1'b0;
            rd_ch    <= '0;
            rd_blend <= 1'b0;
            rd_sa    <= '0;
            rd_sb    <= '0;
        end else begin
            rd_vld <= serve;
            if (serve) begin
                slot     <= (slot == CH_W'(NCH-1)) ? '0 : slot + 1'b1;
                rd_ch    <= slot;
                rd_blend <= (mode_a[slot] == MODE_BLEND);
                rd_sa    <= sa_a[slot];
                rd_sb    <= sb_a[slot];
            end
        end
    end

    // Phase accumulators and keying-pattern positions, advanced when served.
    always_ff @(posedge clk) begin
        for (int i = 0; i < NCH; i++) begin
            if (!rst_n) begin
                acc[i]     <= '0;
                bit_idx[i] <= '0;
            end else begin
                if (serve && slot == CH_W'(i))
                    acc[i] <= acc[i] + step;
                if (pat_wr[i])
                    bit_idx[i] <= '0;
                else if (serve && slot == CH_W'(i) && mode_a[i] == MODE_FSK_MEM)
                    bit_idx[i] <= bit_idx[i] + 1'b1;
            end
        end
    end

    // Output registers: table sample or mix of two channels' current words.
    always_ff @(posedge clk) begin
        for (int i = 0; i < NCH; i++) begin
            if (!rst_n)
                out_q[i] <= '0;
            else if (rd_vld && rd_ch == CH_W'(i))
                out_q[i] <= rd_blend
                    ? DW'(({1'b0, out_q[rd_sa]} + {1'b0, out_q[rd_sb]}) >> 1)
                    : ram_q;
        end
    end

    // ---- checks guarding the rotation, pause and step limit ----
    logic              chk_vld;
    logic [CH_W-1:0]   chk_ch;
    logic [PW-1:0]     chk_acc;
    logic [PW-1:0]     acc_delta;

    // Capture the served channel's accumulator to measure its advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chk_vld <= 1'b0;
            chk_ch  <= '0;
            chk_acc <= '0;
        end else begin
            chk_vld <= serve;
            chk_ch  <= slot;
            chk_acc <= acc[slot];
        end
    end

    assign acc_delta = acc[chk_ch] - chk_acc;

    // R5: no accumulator ever advances by more than half a cycle
    a_r5_step_cap: assert property (@(posedge clk) disable iff (!rst_n)
        chk_vld |-> (acc_delta <= STEP_CAP));

    // R2: the rotation moves to the next channel after a served clock
    a_r2_rotation: assert property (@(posedge clk) disable iff (!rst_n)
        serve |=> (slot == (($past(slot) == CH_W'(NCH-1)) ? '0 : $past(slot) + 1'b1)));

    // R10: a table write freezes rotation and accumulators
    a_r10_pause: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_we |=> ($stable(slot) && $stable(acc_flat)));

    for (genvar i = 0; i < NCH; i++) begin : g_pat_chk
        // R6: rewriting the pattern restarts keying at bit 0
        a_r6_pattern_restart: assert property (@(posedge clk) disable iff (!rst_n)
            pat_wr[i] |=> (bit_idx[i] == '0));
    end

endmodule

// File: tb/mcdds_top_tb_top.sv
// Bench: behavioural per-clock model of the synthesizer compared on every clock.
module mcdds_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_ch = '0;
    logic [2:0]  cfg_sel = '0;
    logic [31:0] cfg_data = '0;
    logic        tbl_we = 1'b1;
    logic [7:0]  tbl_addr = '0;
    logic [7:0]  tbl_data = 8'd11;
    logic [31:0] fm_in = '0;
    logic [31:0] pm_in = '0;
    logic        fsk_ext = 1'b0;
    logic [31:0] dac_out;

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done = 0;
    string cur_req = "R1";

    always #10 clk = ~clk;

    mcdds_top dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ch(cfg_ch),
        .cfg_sel(cfg_sel), .cfg_data(cfg_data), .tbl_we(tbl_we),
        .tbl_addr(tbl_addr), .tbl_data(tbl_data), .fm_in(fm_in),
        .pm_in(pm_in), .fsk_ext(fsk_ext), .dac_out(dac_out)
    );

    // ---------------- reference model ----------------
    logic [31:0] m_f0[4], m_f1[4], m_ph[4], m_acc[4];
    logic [7:0]  m_kf[4], m_out[4], m_mem[256];
    int          m_mode[4], m_bank[4], m_sa[4], m_sb[4], m_idx[4];
    logic [15:0] m_pat[4];
    int          m_slot;
    bit          p_vld, p_bl;
    int          p_ch, p_sa, p_sb;
    logic [7:0]  p_q;

    initial for (int i = 0; i < 4; i++) m_out[i] = '0;

    function automatic logic [31:0] model_step(int ch, bit one);
        longint v;
        v = longint'(one ? m_f1[ch] : m_f0[ch])
            + longint'($signed(fm_in[ch*8 +: 8])) * longint'(m_kf[ch]);
        if (v < 0) v = 0;
        if (v > 64'h8000_0000) v = 64'h8000_0000;
        return v[31:0];
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) begin
                m_f0[i] = 0; m_f1[i] = 0; m_ph[i] = 0; m_acc[i] = 0; m_kf[i] = 0;
                m_out[i] = 0; m_mode[i] = 0; m_bank[i] = i; m_sa[i] = 0; m_sb[i] = 0;
                m_idx[i] = 0; m_pat[i] = 0;
            end
            m_slot = 0; p_vld = 0;
        end else begin
            if (p_vld)
                m_out[p_ch] = p_bl ? 8'((int'(m_out[p_sa]) + int'(m_out[p_sb])) / 2) : p_q;
            if (tbl_we) begin
                m_mem[tbl_addr] = tbl_data;
                p_vld = 0;
            end else begin
                automatic int s = m_slot;
                automatic bit one = 0;
                automatic logic [31:0] sum;
                if (m_mode[s] == 1) one = m_pat[s][m_idx[s]];
                if (m_mode[s] == 2) one = fsk_ext;
                sum = m_acc[s] + m_ph[s] + {pm_in[s*8 +: 8], 24'h0};
                p_q = m_mem[m_bank[s] * 64 + int'(sum >> 26)];
                p_vld = 1; p_ch = s; p_bl = (m_mode[s] == 3); p_sa = m_sa[s]; p_sb = m_sb[s];
                m_acc[s] = m_acc[s] + model_step(s, one);
                if (m_mode[s] == 1) m_idx[s] = (m_idx[s] + 1) % 16;
                m_slot = (s + 1) % 4;
            end
            if (cfg_we) begin
                case (cfg_sel)
                    3'd0: m_f0[cfg_ch] = cfg_data;
                    3'd1: m_f1[cfg_ch] = cfg_data;
                    3'd2: m_ph[cfg_ch] = cfg_data;
                    3'd3: m_kf[cfg_ch] = cfg_data[7:0];
                    3'd4: m_mode[cfg_ch] = int'(cfg_data[1:0]);
                    3'd5: m_bank[cfg_ch] = int'(cfg_data[1:0]);
                    3'd6: begin m_sa[cfg_ch] = int'(cfg_data[1:0]); m_sb[cfg_ch] = int'(cfg_data[3:2]); end
                    default: begin m_pat[cfg_ch] = cfg_data[15:0]; m_idx[cfg_ch] = 0; end
                endcase
            end
        end
    end

    // Compare every channel's DAC word on each falling edge.
    always @(negedge clk) begin
        if (!done) begin
            for (int i = 0; i < 4; i++) begin
                n_cmp++;
                if (dac_out[i*8 +: 8] !== m_out[i]) begin
                    n_bad++;
                    $display("FAIL %s ch%0d t=%0t actual=%h expected=%h",
                             cur_req, i, $time, dac_out[i*8 +: 8], m_out[i]);
                end
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic cfg(input int ch, input int sel, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_ch = 2'(ch); cfg_sel = 3'(sel); cfg_data = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [7:0] wave_at(int a);
        return 8'((a * 37 + 11) & 255);
    endfunction

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state with table loading held from before release
        run(4);
        rst_n = 1'b1;
        for (int a = 0; a < 256; a++) begin
            tbl_addr = 8'(a); tbl_data = wave_at(a);
            @(negedge clk);
        end
        tbl_we = 1'b0;

        cur_req = "R2";   // rotation and plain lookup
        cfg(0, 0, 32'h0400_0000); cfg(1, 0, 32'h0800_0000);
        cfg(2, 0, 32'h0200_0000); cfg(3, 0, 32'h0100_0000);
        run(100);

        cur_req = "R3";   // phase offset and PM input
        cfg(1, 2, 32'h8000_0000);
        pm_in = {8'h10, 8'h40, 8'h00, 8'hF0};
        run(60);

        cur_req = "R12";  // region re-mapping
        cfg(2, 5, 0); cfg(3, 5, 1);
        run(60);

        cur_req = "R4";   // FM input scaled by sensitivity
        cfg(1, 3, 7);
        for (int k = 0; k < 10; k++) begin
            fm_in[15:8] = 8'(k * 29 - 120);
            run(8);
        end

        cur_req = "R5";   // step limits at both ends
        cfg(2, 0, 32'hFFFF_F000);
        cfg(3, 0, 32'h10); cfg(3, 3, 200); fm_in[31:24] = 8'h9C;
        cfg(0, 0, 32'h8000_0000);
        run(80);
        fm_in = '0;

        cur_req = "R8";   // frequency change keeps phase continuous
        for (int k = 0; k < 6; k++) begin
            cfg(0, 0, 32'h0123_4567 * (k + 1));
            run(7);
        end

        cur_req = "R6";   // stored-pattern keying and restart
        cfg(0, 0, 32'h0400_0000); cfg(0, 1, 32'h2000_0000);
        cfg(0, 7, 32'h0000_A5C3); cfg(0, 4, 1);
        run(100);
        cfg(0, 7, 32'h0000_0F0F);
        run(50);

        cur_req = "R7";   // external keying bit
        cfg(1, 1, 32'h1800_0000); cfg(1, 4, 2);
        for (int k = 0; k < 20; k++) begin
            fsk_ext = k[0];
            run(5);
        end

        cur_req = "R9";   // mix of channels 0 and 1
        cfg(3, 6, 32'h4); cfg(3, 4, 3);
        run(80);

        cur_req = "R10";  // table writes pause the rotation
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            tbl_we = 1'b1; tbl_addr = 8'(k * 7); tbl_data = ~wave_at(k);
            @(negedge clk);
            tbl_we = 1'b0;
            run(k % 3);
        end
        run(60);

        cur_req = "R11";  // assorted register writes
        cfg(2, 2, 32'h3000_0000); cfg(2, 3, 5); cfg(2, 4, 0);
        fm_in[23:16] = 8'h22;
        run(40);

        cur_req = "R1";   // mid-run reset returns to defaults
        @(negedge clk); rst_n = 1'b0;
        run(3);
        rst_n = 1'b1;
        run(40);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule